// File: doc/BRIEF.md
# Thirty-two pin GPIO port with per-pin interrupt detection

The port drives a 32-pin pad ring. Each pin has a direction bit and an output data bit, and both registers go straight to the pads. Pad inputs are brought into the clock domain through a two-flop synchronizer. A per-pin detector watches the synchronized value against the sample taken one cycle earlier. The detector flags a low level, a high level, a rising edge or a falling edge, as chosen by that pin's 2-bit type field. A per-pin "any edge" bit makes the detector fire on both edges and ignore the type field. Flagged events set sticky status bits, which software clears by writing ones. The single interrupt output is high while any status bit whose mask bit is set is itself set.

Software reaches the port over a simple word-addressed register bus. A control state machine has two states. In `BUS_IDLE` it is ready and accepts one request per cycle. A write takes effect on the accepting edge and the machine stays in `BUS_IDLE`. A read loads the read-data register on the accepting edge and takes the transition `BUS_IDLE -> BUS_RESP`. In `BUS_RESP` the read data is valid and ready is low. The machine always takes `BUS_RESP -> BUS_IDLE` on the next edge.

Register map, byte offsets:

| Offset | Contents |
|---|---|
| 0x00 | output data |
| 0x04 | direction |
| 0x08 | synchronized pad inputs, read-only |
| 0x0C | type fields for pins 0..15 |
| 0x10 | type fields for pins 16..31 |
| 0x14 | interrupt mask |
| 0x18 | status, write-one-to-clear |
| 0x1C | any-edge select |

Top module: `gpio_irq_port`

## Requirements
- R1: After reset:
  - pad_oe, pad_out and irq are 0.
  - The data, direction, both type, mask and any-edge registers read back as 0.
- R2: pad_oe equals the direction register, where 1 means output. pad_out equals the data register whatever the direction. A value written to the data register while a pin is an input appears on pad_out in the same cycle the pin becomes an output.
- R3: A read of offset 0x08 returns pad_in after two synchronizer stages. A read accepted on the first edge after a pad change still returns the old value. A read accepted on the fourth edge after the change returns the new value.
- R4: Pin p takes its type field from offset 0x0C for p < 16, or from offset 0x10 for p >= 16. The field sits at bits 2*(p mod 16)+1 : 2*(p mod 16). The encoding is 00 low level, 01 high level, 10 rising edge, 11 falling edge.
- R5: A level-type pin sets its status bit on every cycle its level condition holds. The bit therefore stays set through a clear while the condition holds. Once the condition ends, the bit stays set until it is cleared.
- R6: An edge-type pin sets its status bit once for a matching edge, and not for the opposite edge or a steady level. The bit stays set until cleared.
- R7: When a pin's any-edge bit (offset 0x1C) is 1, the pin sets status on both rising and falling edges, and its type field and steady levels have no effect.
- R8: Writing to offset 0x18 clears each status bit written as 1 and leaves bits written as 0 unchanged. A detection in the same cycle wins over the clear.
- R9: irq is 1 exactly when some status bit and its mask bit (offset 0x14, 1 = enabled) are both 1.
- R10: Bus behaviour:
  - A read accepted while bus_ready is 1 returns its data on bus_rdata with bus_rvalid high in the next cycle, and bus_ready is low during that cycle.
  - Writes to offset 0x08 or to offsets 0x20 and above change nothing.
  - Reads of offsets 0x20 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_sel | input | 1 | request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | byte offset |
| bus_wdata | input | 32 | write data |
| bus_ready | output | 1 | a request can be accepted this cycle |
| bus_rvalid | output | 1 | bus_rdata holds read data |
| bus_rdata | output | 32 | read data |
| pad_in | input | 32 | pad input levels |
| pad_oe | output | 32 | per-pin output enable |
| pad_out | output | 32 | per-pin output value |
| irq | output | 1 | combined interrupt request |

## Verification
The hardest case to reach from the ports is the interaction of sticky status with level detection and with the any-edge override. Showing it needs a pad edge, a clear, and then a read that proves the pin stayed quiet while its level was still held. The stimulus first rewrites every type field to high level and drives all pads low, so that no pin fires by itself. It then places single pins at the field boundaries (pins 5, 7, 20 and 31) and moves only those pads. Every status read is spaced four cycles after a pad change, which covers the two synchronizer stages and the status register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_SLOTS = 8;
    localparam int SLOT_W    = $clog2(REG_SLOTS);

    typedef enum logic [SLOT_W-1:0] {
        RS_DATA    = 3'd0,
        RS_DIR     = 3'd1,
        RS_PAD     = 3'd2,
        RS_TYPE_LO = 3'd3,
        RS_TYPE_HI = 3'd4,
        RS_MASK    = 3'd5,
        RS_STATUS  = 3'd6,
        RS_BOTH    = 3'd7
    } reg_slot_e;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_HIGH = 2'b01,
        DET_RISE = 2'b10,
        DET_FALL = 2'b11
    } det_mode_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= pad_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = prev_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic [N_PINS-1:0] level_i,
    input  logic [N_PINS-1:0] prev_i,
    input  logic [WORD_W-1:0] type_lo_i,
    input  logic [WORD_W-1:0] type_hi_i,
    input  logic [N_PINS-1:0] both_i,
    output logic [N_PINS-1:0] hit_o
);

    localparam int PER_REG = WORD_W / 2;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [1:0] field;
        det_mode_e  mode;

        if (p < PER_REG) begin : g_lo
            assign field = type_lo_i[2*p +: 2];
        end else begin : g_hi
            assign field = type_hi_i[2*(p-PER_REG) +: 2];
        end

        assign mode = det_mode_e'(field);

        always_comb begin
            if (both_i[p]) begin
                hit_o[p] = level_i[p] ^ prev_i[p];
            end else begin
                unique case (mode)
                    DET_LOW:  hit_o[p] = ~level_i[p];
                    DET_HIGH: hit_o[p] = level_i[p];
                    DET_RISE: hit_o[p] = level_i[p] & ~prev_i[p];
                    DET_FALL: hit_o[p] = ~level_i[p] & prev_i[p];
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] hit_i,
    input  logic [N_PINS-1:0] clear_i,
    output logic [N_PINS-1:0] status_o
);

    logic [N_PINS-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clear_i) | hit_i;
    end

    assign status_o = status_q;

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    rd_word_i,
    output logic                 ready_o,
    output logic                 rvalid_o,
    output logic [WORD_W-1:0]    rdata_o,
    output logic [REG_SLOTS-1:0] wr_en_o,
    output reg_slot_e            slot_o,
    output logic                 slot_ok_o
);

    localparam int LSB_W = 2;

    bus_state_e        state_q, state_d;
    logic              accept;
    logic [WORD_W-1:0] rdata_q;

    assign slot_o    = reg_slot_e'(addr_i[LSB_W +: SLOT_W]);
    assign slot_ok_o = (addr_i[ADDR_W-1:LSB_W+SLOT_W] == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (sel_i && !wr_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready_o  = 1'b0;
        rvalid_o = 1'b0;
        unique case (state_q)
            BUS_IDLE: ready_o  = 1'b1;
            BUS_RESP: rvalid_o = 1'b1;
        endcase
        accept  = sel_i && ready_o;
        wr_en_o = '0;
        if (accept && wr_i && slot_ok_o) wr_en_o[slot_o] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (accept && !wr_i)  rdata_q <= rd_word_i;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int N_PINS      = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic              irq
);

    logic [N_PINS-1:0]    data_q, dir_q, mask_q, both_q;
    logic [WORD_W-1:0]    type_lo_q, type_hi_q;
    logic [N_PINS-1:0]    level_s, prev_s, hit_vec, status_q, clear_vec;
    logic [REG_SLOTS-1:0] wr_en;
    reg_slot_e            slot;
    logic                 slot_ok;
    logic [WORD_W-1:0]    rd_word;

    gpio_pad_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (pad_in),
        .level_o (level_s),
        .prev_o  (prev_s)
    );

    gpio_edge_detect #(.N_PINS(N_PINS)) u_detect (
        .level_i   (level_s),
        .prev_i    (prev_s),
        .type_lo_i (type_lo_q),
        .type_hi_i (type_hi_q),
        .both_i    (both_q),
        .hit_o     (hit_vec)
    );

    gpio_irq_status #(.N_PINS(N_PINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_vec),
        .clear_i  (clear_vec),
        .status_o (status_q)
    );

    gpio_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .rd_word_i (rd_word),
        .ready_o   (bus_ready),
        .rvalid_o  (bus_rvalid),
        .rdata_o   (bus_rdata),
        .wr_en_o   (wr_en),
        .slot_o    (slot),
        .slot_ok_o (slot_ok)
    );

    assign clear_vec = wr_en[RS_STATUS] ? bus_wdata[N_PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            dir_q     <= '0;
            mask_q    <= '0;
            both_q    <= '0;
            type_lo_q <= '0;
            type_hi_q <= '0;
        end else begin
            if (wr_en[RS_DATA])    data_q    <= bus_wdata[N_PINS-1:0];
            if (wr_en[RS_DIR])     dir_q     <= bus_wdata[N_PINS-1:0];
            if (wr_en[RS_MASK])    mask_q    <= bus_wdata[N_PINS-1:0];
            if (wr_en[RS_BOTH])    both_q    <= bus_wdata[N_PINS-1:0];
            if (wr_en[RS_TYPE_LO]) type_lo_q <= bus_wdata;
            if (wr_en[RS_TYPE_HI]) type_hi_q <= bus_wdata;
        end
    end

    always_comb begin
        rd_word = '0;
        if (slot_ok) begin
            unique case (slot)
                RS_DATA:    rd_word[N_PINS-1:0] = data_q;
                RS_DIR:     rd_word[N_PINS-1:0] = dir_q;
                RS_PAD:     rd_word[N_PINS-1:0] = level_s;
                RS_TYPE_LO: rd_word             = type_lo_q;
                RS_TYPE_HI: rd_word             = type_hi_q;
                RS_MASK:    rd_word[N_PINS-1:0] = mask_q;
                RS_STATUS:  rd_word[N_PINS-1:0] = status_q;
                RS_BOTH:    rd_word[N_PINS-1:0] = both_q;
            endcase
        end
    end

    assign pad_oe  = dir_q;
    assign pad_out = data_q;
    assign irq     = |(status_q & mask_q);

endmodule

// File: rtl/gpio_irq_port_checker.sv
module gpio_irq_port_checker #(
    parameter int N_PINS = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_ready,
    input logic              bus_rvalid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] pad_out,
    input logic              irq,
    input logic [N_PINS-1:0] status,
    input logic [N_PINS-1:0] hit
);

    localparam logic [ADDR_W-1:0] OFS_DATA   = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_DIR    = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(8'h14);
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(8'h18);

    logic              wr_go;
    logic [N_PINS-1:0] clr_req;

    assign wr_go   = bus_sel && bus_wr && bus_ready;
    assign clr_req = (wr_go && bus_addr == OFS_STATUS) ? bus_wdata[N_PINS-1:0] : '0;

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata[N_PINS-1:0])));

    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && bus_addr == OFS_DATA) |=> (pad_out == $past(bus_wdata[N_PINS-1:0])));

    assert_set_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));

    assert_clear_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~status & ~$past(clr_req)) == '0));

    assert_mask_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && bus_addr == OFS_MASK && bus_wdata[N_PINS-1:0] == '0) |=> !irq);

    assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    assert_read_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_ready) |=> (bus_rvalid && !bus_ready));

endmodule

bind gpio_irq_port gpio_irq_port_checker #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .irq        (irq),
    .status     (status_q),
    .hit        (hit_vec)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;

    localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_PAD = 6'h08, A_TLO = 6'h0C,
                           A_THI = 6'h10, A_MASK = 6'h14, A_STAT = 6'h18, A_BOTH = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid, irq;
    logic [31:0] bus_rdata, pad_oe, pad_out;
    logic [31:0] pad_in = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per read response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) chk("R10 unexpected response", 32'h1, 32'h0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R10 ready low in response", {31'b0, bus_ready}, 32'h0);
        @(negedge clk);
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_DATA, 32'h0, "R1 data");
        rd(A_DIR,  32'h0, "R1 dir");
        rd(A_TLO,  32'h0, "R1 type lo");
        rd(A_THI,  32'h0, "R1 type hi");
        rd(A_MASK, 32'h0, "R1 mask");
        rd(A_BOTH, 32'h0, "R1 any-edge");
        // R5: default type is low level, pads low -> every pin flagged
        rd(A_STAT, 32'hFFFF_FFFF, "R5 low level default");

        // R2 output path
        wr(A_DATA, 32'hA5A5_0F0F);
        chk("R2 pad_out as input", pad_out, 32'hA5A5_0F0F);
        chk("R2 oe still off", pad_oe, 32'h0);
        wr(A_DIR, 32'h0000_FFFF);
        chk("R2 oe follows dir", pad_oe, 32'h0000_FFFF);
        chk("R2 preset value on pin", pad_out, 32'hA5A5_0F0F);
        rd(A_DATA, 32'hA5A5_0F0F, "R2 data readback");

        // R3 synchronizer latency
        set_pad(32'h1234_5678);
        rd(A_PAD, 32'h0, "R3 old pad value");
        rd(A_PAD, 32'h1234_5678, "R3 new pad value");

        // quiet configuration: all high level, pads low, clear
        wr(A_TLO, 32'h5555_5555);
        wr(A_THI, 32'h5555_5555);
        set_pad(32'h0);
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R8 clear all");

        // R5 / R8 / R9 with high level on pin 0
        wr(A_MASK, 32'h1);
        set_pad(32'h1);
        idle(4);
        chk("R9 irq on enabled pin", {31'b0, irq}, 32'h1);
        rd(A_STAT, 32'h1, "R5 high level sets");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h1, "R5 resets while held");
        set_pad(32'h0);
        idle(4);
        rd(A_STAT, 32'h1, "R5 sticky after level ends");
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h1, "R8 write zero keeps");
        wr(A_STAT, 32'h1);
        rd(A_STAT, 32'h0, "R8 write one clears");
        chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
        set_pad(32'h2);
        idle(4);
        chk("R9 masked pin quiet", {31'b0, irq}, 32'h0);
        rd(A_STAT, 32'h2, "R9 status set while masked");
        wr(A_MASK, 32'h2);
        chk("R9 unmask raises irq", {31'b0, irq}, 32'h1);
        set_pad(32'h0);
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        idle(1);
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);

        // R4 field placement: pin5 rise (lo bits 11:10=10), pin20 fall (hi bits 9:8=11),
        // pin31 low level (hi bits 31:30=00)
        wr(A_TLO, 32'h5555_5955);
        wr(A_THI, 32'h1555_5755);
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h8000_0000, "R4 pin31 low level from hi reg");
        set_pad(32'h8000_0000);
        idle(4);
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, 32'h0, "R4 pin31 quiet when high");

        // R6 edges
        set_pad(32'h8000_0020);
        idle(4);
        rd(A_STAT, 32'h0000_0020, "R6 pin5 rising");
        wr(A_STAT, 32'h0000_0020);
        idle(2);
        rd(A_STAT, 32'h0, "R6 no repeat while high");
        set_pad(32'h8000_0000);
        idle(4);
        rd(A_STAT, 32'h0, "R6 falling ignored on rise pin");
        set_pad(32'h8010_0000);
        idle(4);
        rd(A_STAT, 32'h0, "R6 rising ignored on fall pin");
        set_pad(32'h8000_0000);
        idle(4);
        rd(A_STAT, 32'h0010_0000, "R6 pin20 falling");
        wr(A_STAT, 32'h0010_0000);

        // R7 any-edge on pin20 (fall type) and pin7 (high level type)
        wr(A_BOTH, 32'h0010_0080);
        set_pad(32'h8010_0000);
        idle(4);
        rd(A_STAT, 32'h0010_0000, "R7 rising with any-edge");
        wr(A_STAT, 32'h0010_0000);
        set_pad(32'h8000_0000);
        idle(4);
        rd(A_STAT, 32'h0010_0000, "R7 falling with any-edge");
        wr(A_STAT, 32'h0010_0000);
        set_pad(32'h8000_0080);
        idle(4);
        rd(A_STAT, 32'h0000_0080, "R7 pin7 edge");
        wr(A_STAT, 32'h0000_0080);
        idle(3);
        rd(A_STAT, 32'h0, "R7 level type ignored");

        // R10 ignored writes and unmapped reads
        wr(6'h20, 32'hFFFF_FFFF);
        wr(A_PAD, 32'hFFFF_FFFF);
        rd(A_DATA, 32'hA5A5_0F0F, "R10 data untouched");
        rd(A_DIR,  32'h0000_FFFF, "R10 dir untouched");
        rd(A_MASK, 32'h0000_0002, "R10 mask untouched");
        rd(6'h24,  32'h0, "R10 unmapped reads zero");
        rd(A_PAD,  32'h8000_0080, "R10 pad read not written");
        chk("R10 pad_oe unchanged", pad_oe, 32'h0000_FFFF);
        idle(2);
        chk("R10 all responses seen", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule